// File: doc/BRIEF.md
# Glitch-free Clock Stop Gate

This block sits after the clock dividers of a clock generator. It gates a set of divided output clocks in response to asynchronous, active-low stop requests, one per output group. Each request first passes through a synchronizer clocked by the internal reference clock. A per-group controller then raises or drops an enable request. It applies programmable extra off and on delays and a minimum-run guard. Every output has a gate cell that takes a new enable value only while its source clock is low. An output therefore parks at logic 0 and restarts with a complete high phase.

A mode strap is sampled on the first reference clock edge after reset. With the strap at 0 the stop pins are honoured and the auxiliary memory-clock outputs stay low. With the strap at 1 the stop requests are ignored, and the same pin positions carry gated copies of a memory source clock instead. A per-output enable mask, normally driven from a configuration register, holds individual outputs low. Selected outputs are marked free-running and never respond to their group's stop request.

Each output belongs to one group, given by a 4-bit field in `GROUP_MAP`: output i reads bits [4i+3:4i]. All source clocks are level signals that change only just after a rising reference edge.

Top module: `clk_stop_gate`

## Requirements
- R1: While `rst_n` is low, every `clk_out` and `aux_out` bit is 0. After reset, with all enables at 1 and no stop requested, every output toggles with the source of its group.
- R2: An output is never 1 while its source clock is 0. A stopped or masked output rests at 0.
- R3: An output rises only on the same edge as a rise of its source, and falls only on the same edge as a fall of its source. No shortened high phase is produced.
- R4: The stop request of group g passes through a two-flop synchronizer. The non-free outputs of group g stop within 5+OFF_DLY(g)+P(g) reference cycles of `stop_n[g]` going low. They show their first rising edge within 5+ON_DLY(g)+P(g) reference cycles of its release. P(g) is the source period in reference cycles, and OFF_DLY(g) and ON_DLY(g) are the 16-bit fields g of `OFF_DLY_V` and `ON_DLY_V`. The defaults are OFF_DLY = {0,0,2} and ON_DLY = 0 for groups 0, 1 and 2.
- R5: Once a group's enable request is restored, it stays asserted for at least MIN_RUN(g) reference cycles, even if the stop pin is asserted again at once. MIN_RUN(g) is the 16-bit field g of `MIN_RUN_V`, with defaults 200, 30 and 8.
- R6: The mode strap is captured on the first clock edge after reset and held until the next reset. Latched mode 1 ignores all stop pins, and `aux_out[g]` follows `mem_src` when `aux_en[g]` is 1 and rests at 0 when it is 0. Latched mode 0 keeps `aux_out` at 0.
- R7: Outputs whose `FREE_MASK` bit is 1 keep running when their group's stop pin is asserted. By default these are outputs 4 and 5.
- R8: An output whose `out_en` bit is 0 is held at 0 and does not toggle. A change in the mask takes effect only during the low phase of the source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal reference clock (stop synchronization and gate timing) |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_strap | input | 1 | Mode strap, captured once after reset |
| stop_n | input | NGRP | Asynchronous active-low stop request per group |
| src_clk | input | NGRP | Divided source clock per group, synchronous to clk |
| mem_src | input | 1 | Memory source clock used for the auxiliary outputs |
| out_en | input | NOUT | Per-output enable mask (1 = enabled) |
| aux_en | input | NGRP | Per-pin enable for the auxiliary memory outputs |
| clk_out | output | NOUT | Gated output clocks |
| aux_out | output | NGRP | Auxiliary memory clock outputs (mode 1 only) |

## Verification
Several behaviours are checked by assertions on every cycle:
- no output is ever high while its source is low;
- rises and falls coincide with source edges;
- a masked output that is already low stays low;
- the enable request of a group never drops before its minimum-run count is reached;
- latched mode 1 keeps every group enabled, and latched mode 0 keeps the auxiliary outputs low.

Only the bench's scenarios can show the rest:
- the off and on latency bounds through the synchronizer;
- the immunity of free-running outputs to stop requests;
- the group mapping;
- the strap being held after it changes;
- the mixed random stop and mask patterns, each compared against a computed run or stopped expectation.

// File: rtl/csg_pkg.sv
`timescale 1ns/1ps
package csg_pkg;
  localparam int MAP_W = 4;    // bits per group-index field in the output map
  localparam int CNT_W = 16;   // bits per delay / min-run field
  localparam int VEC_W = 128;  // widest parameter vector handled by pick()

  // Extract field idx (width w) from a packed parameter vector.
  function automatic int unsigned pick(input logic [VEC_W-1:0] vec,
                                       input int unsigned idx,
                                       input int unsigned w);
    logic [VEC_W-1:0] sh;
    sh = (vec >> (idx * w)) & ((VEC_W'(1) << w) - VEC_W'(1));
    return sh[31:0];
  endfunction

  // Gate enable update: hold while the source is high, follow the request while low.
  function automatic logic gate_next(input logic en_q, input logic want, input logic src);
    return src ? en_q : want;
  endfunction
endpackage

// File: rtl/csg_sync.sv
`timescale 1ns/1ps
module csg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  // Resets to the released level so a group runs out of reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '1;
    else        sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/csg_stop_ctrl.sv
`timescale 1ns/1ps
module csg_stop_ctrl import csg_pkg::*; #(
  parameter int OFF_DLY = 0,
  parameter int ON_DLY  = 0,
  parameter int MIN_RUN = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want_stop,
  output logic en_req
);
  localparam logic [CNT_W-1:0] OFF_L = CNT_W'(OFF_DLY);
  localparam logic [CNT_W-1:0] ON_L  = CNT_W'(ON_DLY);
  localparam logic [CNT_W-1:0] RUN_L = CNT_W'(MIN_RUN);

  logic [CNT_W-1:0] dly_cnt;
  logic [CNT_W-1:0] run_cnt;
  logic             run_ok;

  assign run_ok = (run_cnt >= RUN_L);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_req  <= 1'b1;
      dly_cnt <= '0;
      run_cnt <= RUN_L;
    end else if (en_req) begin
      if (!run_ok) run_cnt <= run_cnt + 1'b1;
      if (want_stop && run_ok) begin
        if (dly_cnt == OFF_L) begin
          en_req  <= 1'b0;
          dly_cnt <= '0;
        end else begin
          dly_cnt <= dly_cnt + 1'b1;
        end
      end else begin
        dly_cnt <= '0;
      end
    end else begin
      if (!want_stop) begin
        if (dly_cnt == ON_L) begin
          en_req  <= 1'b1;
          dly_cnt <= '0;
          run_cnt <= '0;
        end else begin
          dly_cnt <= dly_cnt + 1'b1;
        end
      end else begin
        dly_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/csg_gate_cell.sv
`timescale 1ns/1ps
module csg_gate_cell import csg_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic want,
  output logic gclk
);
  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= gate_next(en_q, want, src);
  end

  assign gclk = src & en_q;
endmodule

// File: rtl/clk_stop_gate.sv
`timescale 1ns/1ps
module clk_stop_gate import csg_pkg::*; #(
  parameter int                     NGRP        = 3,
  parameter int                     NOUT        = 8,
  parameter logic [MAP_W*NOUT-1:0]  GROUP_MAP   = 32'h2221_1100,
  parameter logic [NOUT-1:0]        FREE_MASK   = 8'h30,
  parameter logic [CNT_W*NGRP-1:0]  OFF_DLY_V   = 48'h0002_0000_0000,
  parameter logic [CNT_W*NGRP-1:0]  ON_DLY_V    = 48'h0000_0000_0000,
  parameter logic [CNT_W*NGRP-1:0]  MIN_RUN_V   = 48'h0008_001E_00C8,
  parameter int                     SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_strap,
  input  logic [NGRP-1:0] stop_n,
  input  logic [NGRP-1:0] src_clk,
  input  logic            mem_src,
  input  logic [NOUT-1:0] out_en,
  input  logic [NGRP-1:0] aux_en,
  output logic [NOUT-1:0] clk_out,
  output logic [NGRP-1:0] aux_out
);
  // Named internal events (observed by the bound checker)
  logic            mode_lat;
  logic            mode_done;
  logic [NGRP-1:0] stop_sync;
  logic [NGRP-1:0] want_stop;
  logic [NGRP-1:0] grp_en_req;
  logic [NOUT-1:0] out_src;
  logic [NOUT-1:0] out_want;

  // Strap capture on the first edge after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_lat  <= 1'b0;
      mode_done <= 1'b0;
    end else if (!mode_done) begin
      mode_lat  <= mode_strap;
      mode_done <= 1'b1;
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int OFF_G = int'(pick(VEC_W'(OFF_DLY_V), g, CNT_W));
    localparam int ON_G  = int'(pick(VEC_W'(ON_DLY_V),  g, CNT_W));
    localparam int RUN_G = int'(pick(VEC_W'(MIN_RUN_V), g, CNT_W));

    csg_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(stop_n[g]), .q(stop_sync[g])
    );

    assign want_stop[g] = ~stop_sync[g] & ~mode_lat;

    csg_stop_ctrl #(.OFF_DLY(OFF_G), .ON_DLY(ON_G), .MIN_RUN(RUN_G)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .want_stop(want_stop[g]), .en_req(grp_en_req[g])
    );

    csg_gate_cell u_aux (
      .clk(clk), .rst_n(rst_n), .src(mem_src),
      .want(mode_lat & aux_en[g]), .gclk(aux_out[g])
    );
  end

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    localparam int GI = int'(pick(VEC_W'(GROUP_MAP), i, MAP_W));

    assign out_src[i]  = src_clk[GI];
    assign out_want[i] = out_en[i] & (FREE_MASK[i] | grp_en_req[GI]);

    csg_gate_cell u_gate (
      .clk(clk), .rst_n(rst_n), .src(out_src[i]),
      .want(out_want[i]), .gclk(clk_out[i])
    );
  end
endmodule

// File: rtl/clk_stop_gate_chk.sv
`timescale 1ns/1ps
module clk_stop_gate_chk import csg_pkg::*; #(
  parameter int                    NGRP      = 3,
  parameter int                    NOUT      = 8,
  parameter logic [CNT_W*NGRP-1:0] MIN_RUN_V = '0
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NOUT-1:0] clk_out,
  input logic [NOUT-1:0] out_src,
  input logic [NOUT-1:0] out_en,
  input logic [NGRP-1:0] grp_en_req,
  input logic            mode_lat,
  input logic [NGRP-1:0] aux_out
);
  p_out_le_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_out & ~out_src) == '0);

  p_edge_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (((clk_out & ~$past(clk_out)) & ~(out_src & ~$past(out_src))) == '0) &&
    (((~clk_out & $past(clk_out)) & ~(~out_src & $past(out_src))) == '0));

  p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_out & ~out_en & ~$past(out_en) & ~$past(clk_out)) == '0);

  p_mode_ign_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_lat |-> (&grp_en_req));

  p_aux_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_lat |-> (aux_out == '0));

  for (genvar g = 0; g < NGRP; g++) begin : g_run
    localparam logic [CNT_W-1:0] MR = MIN_RUN_V[g*CNT_W +: CNT_W];
    logic [CNT_W-1:0] seen;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              seen <= MR;
      else if (!grp_en_req[g]) seen <= '0;
      else if (seen < MR)      seen <= seen + 1'b1;
    end

    p_min_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(grp_en_req[g]) |-> (seen >= MR));
  end
endmodule

bind clk_stop_gate clk_stop_gate_chk #(
  .NGRP(NGRP), .NOUT(NOUT), .MIN_RUN_V(MIN_RUN_V)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_out(clk_out), .out_src(out_src),
  .out_en(out_en), .grp_en_req(grp_en_req), .mode_lat(mode_lat), .aux_out(aux_out)
);

// File: tb/clk_stop_gate_tb.sv
`timescale 1ns/1ps
module clk_stop_gate_tb;
  localparam int NG = 3;
  localparam int NO = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_strap = 1'b0;
  logic [NG-1:0] stop_n = '1;
  logic [NG-1:0] src_clk = '0;
  logic          mem_src = 1'b0;
  logic [NO-1:0] out_en = '1;
  logic [NG-1:0] aux_en = '1;
  logic [NO-1:0] clk_out;
  logic [NG-1:0] aux_out;

  int n_chk = 0;
  int n_err = 0;
  int mon_r2 = 0;
  int mon_r3 = 0;
  int unsigned rise_cnt [NO];
  int unsigned arise_cnt[NG];
  int unsigned base_r [NO];
  int unsigned base_a [NG];
  int unsigned delta_r[NO];
  int unsigned delta_a[NG];
  int unsigned cyc = 0;

  clk_stop_gate u_dut (
    .clk(clk), .rst_n(rst_n), .mode_strap(mode_strap), .stop_n(stop_n),
    .src_clk(src_clk), .mem_src(mem_src), .out_en(out_en), .aux_en(aux_en),
    .clk_out(clk_out), .aux_out(aux_out)
  );

  always #2 clk = ~clk;

  // Requirement-side model of the configuration
  function automatic int grp_of(input int i);
    if (i < 2) return 0;
    if (i < 5) return 1;
    return 2;
  endfunction
  function automatic bit is_free(input int i);
    return (i == 4) || (i == 5);
  endfunction
  function automatic int per_of(input int g);
    return (g == 0) ? 2 : (g == 1) ? 6 : 4;
  endfunction
  function automatic int off_of(input int g);
    return (g == 2) ? 2 : 0;
  endfunction
  function automatic int off_bound(input int g);
    return 5 + off_of(g) + per_of(g);
  endfunction
  function automatic int on_bound(input int g);
    return 5 + 0 + per_of(g);
  endfunction
  function automatic logic [NO-1:0] exp_vec(input logic [NG-1:0] st, input logic [NO-1:0] en,
                                            input bit mode);
    logic [NO-1:0] v;
    for (int i = 0; i < NO; i++) v[i] = en[i] && (is_free(i) || mode || st[grp_of(i)]);
    return v;
  endfunction

  // Divided sources, updated just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      src_clk[0] = cyc[0];
      src_clk[1] = (cyc % 6) < 3;
      src_clk[2] = (cyc % 4) < 2;
      mem_src    = ~cyc[0];
    end
  end

  // Edge monitor (R2, R3) and rise counters
  initial begin
    logic [NO-1:0] po;
    logic [NO-1:0] ps;
    logic [NG-1:0] pa;
    po = '0; ps = '0; pa = '0;
    forever begin
      @(negedge clk);
      for (int i = 0; i < NO; i++) begin
        logic s;
        s = src_clk[grp_of(i)];
        if (rst_n) begin
          if (clk_out[i] && !s) mon_r2++;
          if (clk_out[i] && !po[i]) begin
            rise_cnt[i]++;
            if (!(s && !ps[i])) mon_r3++;
          end
          if (!clk_out[i] && po[i] && !(!s && ps[i])) mon_r3++;
        end
        ps[i] = s;
      end
      for (int g = 0; g < NG; g++) begin
        if (rst_n && aux_out[g] && !pa[g]) arise_cnt[g]++;
        if (rst_n && aux_out[g] && !mem_src) mon_r2++;
      end
      po = clk_out;
      pa = aux_out;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(input int n);
    for (int i = 0; i < NO; i++) base_r[i] = rise_cnt[i];
    for (int g = 0; g < NG; g++) base_a[g] = arise_cnt[g];
    wait_cyc(n);
    for (int i = 0; i < NO; i++) delta_r[i] = rise_cnt[i] - base_r[i];
    for (int g = 0; g < NG; g++) delta_a[g] = arise_cnt[g] - base_a[g];
  endtask

  task automatic check_outs(input logic [NO-1:0] exp_run, input string req);
    for (int i = 0; i < NO; i++) begin
      if (exp_run[i])
        chk(delta_r[i] > 0, req, $sformatf("out%0d running (rises)", i), int'(delta_r[i]), 1);
      else
        chk(delta_r[i] == 0, req, $sformatf("out%0d stopped (rises)", i), int'(delta_r[i]), 0);
    end
  endtask

  task automatic check_aux(input logic [NG-1:0] exp_run, input string req);
    for (int g = 0; g < NG; g++) begin
      if (exp_run[g])
        chk(delta_a[g] > 0, req, $sformatf("aux%0d running", g), int'(delta_a[g]), 1);
      else
        chk(delta_a[g] == 0, req, $sformatf("aux%0d low", g), int'(delta_a[g]), 0);
    end
  endtask

  task automatic finish_run();
    chk(mon_r2 == 0, "R2", "output high while source low", mon_r2, 0);
    chk(mon_r3 == 0, "R3", "edge not aligned with source edge", mon_r3, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  // Watchdog
  initial begin
    #200000;
    n_err++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int first;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NO; i++) rise_cnt[i] = 0;
    for (int g = 0; g < NG; g++) arise_cnt[g] = 0;

    // R1: reset state
    wait_cyc(6);
    chk(clk_out == '0, "R1", "clk_out in reset", int'(clk_out), 0);
    chk(aux_out == '0, "R1", "aux_out in reset", int'(aux_out), 0);
    rst_n = 1'b1;
    wait_cyc(10);
    measure(30);
    check_outs('1, "R1");
    check_aux('0, "R6");

    // R4 / R7: per-group stop and restart latency
    for (int g = 0; g < NG; g++) begin
      int fo;
      fo = (g == 0) ? 0 : (g == 1) ? 2 : 6;
      stop_n[g] = 1'b0;
      wait_cyc(off_bound(g));
      measure(30);
      check_outs(exp_vec(stop_n, out_en, 1'b0), "R4");
      if (g == 1) chk(delta_r[4] > 0, "R7", "free out4 ignores stop", int'(delta_r[4]), 1);
      if (g == 2) chk(delta_r[5] > 0, "R7", "free out5 ignores stop", int'(delta_r[5]), 1);
      base_r[fo] = rise_cnt[fo];
      stop_n[g] = 1'b1;
      first = 0;
      for (int k = 1; k <= 40; k++) begin
        @(negedge clk);
        if (first == 0 && rise_cnt[fo] != base_r[fo]) first = k;
      end
      chk(first > 0 && first <= on_bound(g), "R4",
          $sformatf("group%0d restart latency", g), first, on_bound(g));
      wait_cyc(240);
    end

    // R5: minimum run after release on group 0 (200 reference cycles)
    stop_n[0] = 1'b0;
    wait_cyc(20);
    stop_n[0] = 1'b1;
    wait_cyc(6);
    stop_n[0] = 1'b0;
    measure(170);
    chk(delta_r[0] > 50, "R5", "out0 keeps running during min run", int'(delta_r[0]), 51);
    chk(delta_r[1] > 50, "R5", "out1 keeps running during min run", int'(delta_r[1]), 51);
    wait_cyc(54);
    measure(30);
    chk(delta_r[0] == 0, "R5", "out0 stops after min run", int'(delta_r[0]), 0);
    chk(delta_r[1] == 0, "R5", "out1 stops after min run", int'(delta_r[1]), 0);
    stop_n[0] = 1'b1;
    wait_cyc(20);

    // R8: enable mask
    out_en[1] = 1'b0;
    out_en[6] = 1'b0;
    wait_cyc(10);
    measure(30);
    check_outs(exp_vec(stop_n, out_en, 1'b0), "R8");
    chk(clk_out[1] == 1'b0, "R8", "masked out1 level", int'(clk_out[1]), 0);
    out_en = '1;
    wait_cyc(10);
    measure(30);
    check_outs('1, "R8");

    // Random mix of stops and masks (R4, R7, R8)
    for (int it = 0; it < 8; it++) begin
      stop_n = NG'($urandom);
      out_en = NO'($urandom);
      wait_cyc(230);
      measure(30);
      check_outs(exp_vec(stop_n, out_en, 1'b0), "R4");
    end
    stop_n = '1;
    out_en = '1;

    // R6: mode 1 latched, strap then changed
    rst_n = 1'b0;
    mode_strap = 1'b1;
    stop_n = '0;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(3);
    mode_strap = 1'b0;
    wait_cyc(20);
    measure(30);
    check_outs('1, "R6");
    check_aux('1, "R6");
    aux_en[2] = 1'b0;
    wait_cyc(6);
    measure(30);
    check_aux(3'b011, "R6");
    chk(aux_out[2] == 1'b0, "R6", "disabled aux2 level", int'(aux_out[2]), 0);

    finish_run();
  end
endmodule